// File: doc/BRIEF.md
# Multi-master I2C bit engine

This block is the bit-level half of an I2C master that shares its bus with other masters. It pulls SCL and SDA low through open-drain enables and reads the real line levels back through a two-flop synchronizer. A controller above it issues three commands. A start command produces a START. A write command shifts out one byte, most significant bit first. A stop command produces a STOP. Byte framing beyond this, acknowledge handling and the slave role belong to other logic.

SCL is built from phase ticks. Each tick lasts 2*(1+tpr) system clocks, and one bit period is ten ticks: six with SCL pulled low, then four with SCL released. So an SCL period is 20*(1+tpr) clocks. For example, a 20 MHz system clock with tpr=2 gives 60 clocks, about 333 kHz. The engine tracks bus occupancy from START and STOP conditions it observes on the lines. During every bit it transmits, it compares SDA with what it sends while SCL is high. If it loses arbitration, it lets go of both lines and waits quietly until the bus is free.

Top module: `i2c_mm_bit_engine`

## Requirements
- R1: Right after reset, scl_oe, sda_oe, busy, done and arb_lost are 0 and bus_idle is 1.
- R2: During a byte write, each bit lasts exactly 20*(1+tpr) clocks. SCL is pulled low for the first 12*(1+tpr) clocks and released for the remaining 8*(1+tpr) clocks.
- R3: A start command is taken only when the engine is idle and bus_idle is 1. SCL stays released throughout the START. SDA is released for 4 ticks and then pulled low for 6 ticks. After that SCL is pulled low and done is high for one cycle.
- R4: A write command after a START or a finished byte sends wr_byte MSB first. For a 0 bit sda_oe is 1, and for a 1 bit it is 0. After the 8th bit, SCL stays pulled low, SDA keeps the level of the last bit, and done pulses for one cycle.
- R5: A stop command pulls SDA low for 10 ticks, with SCL low for 6 of them and released for 4. SDA is then released for 4 ticks with SCL released. The engine then goes idle with a one-cycle done.
- R6: bus_idle goes to 0 when the synchronized SDA falls while the synchronized SCL is high. It goes back to 1 when SDA rises while SCL is high.
- R7: Loss is tested in the last two ticks of a 1 bit. If the engine sends a 1 there and sees SDA low, then from the next cycle both enables are 0 and arb_lost is 1. busy stays 1 until bus_idle returns, and then the engine goes idle without a done pulse.
- R8: arb_lost stays set until a start command is accepted, and the accepted start clears it.
- R9: The second released tick of a bit or STOP does not end until SCL is actually seen high, so a device holding SCL low lengthens the period.
- R10: tpr is captured when a start is accepted. Changing it later in the transfer does not change the bit timing.
- R11: A command that is not valid in the present state is ignored. This covers write and stop while idle, and start while bus_idle is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tpr | input | TPR_W | Timer period; a tick is 2*(1+tpr) clocks |
| cmd_start | input | 1 | Request a START |
| cmd_write | input | 1 | Request a byte write |
| cmd_stop | input | 1 | Request a STOP |
| wr_byte | input | 8 | Byte to transmit, MSB first |
| scl_in | input | 1 | Actual SCL line level |
| sda_in | input | 1 | Actual SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Engine is not idle |
| bus_idle | output | 1 | No transfer is seen on the bus |
| done | output | 1 | One-cycle pulse when a START, byte or STOP completes |
| arb_lost | output | 1 | Sticky arbitration-loss flag |

## Verification
The assertions check the following on every cycle. An idle engine never drives a line. busy can only rise after an accepted start on a free bus. Losing arbitration releases both lines at once and keeps them released for the whole back-off. arb_lost clears only through a start command. done is a single-cycle pulse, and busy never falls without either done or a loss. The bench's scenarios are the only place that shows the exact tick lengths and the bit order on SDA. They also show that a tpr change mid-transfer has no effect, that clock stretching delays the high phase, and in which bit a loss happens, since all of these depend on a timed reference and on an external device acting on the lines.

// File: rtl/i2c_mm_bit_engine.sv
module i2c_mm_bit_engine #(
  parameter int TPR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TPR_W-1:0] tpr,
  input  logic             cmd_start,
  input  logic             cmd_write,
  input  logic             cmd_stop,
  input  logic [7:0]       wr_byte,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             bus_idle,
  output logic             done,
  output logic             arb_lost
);
  localparam int CW = TPR_W + 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_HOLD, S_WRITE, S_STOP, S_BACK} st_t;

  st_t              st;
  logic [TPR_W-1:0] tpr_q;
  logic [CW-1:0]    pcnt;
  logic [3:0]       ph;
  logic [2:0]       nbit;
  logic [7:0]       shr;
  logic             hold_sda;
  logic [1:0]       scl_sy, sda_sy;
  logic             sda_p;

  wire          scl_s = scl_sy[1];
  wire          sda_s = sda_sy[1];
  wire [CW-1:0] plim  = {1'b0, tpr_q, 1'b1};
  wire          tick  = (pcnt == plim);
  wire          stall = (st == S_WRITE || st == S_STOP) && ph == 4'd7 && !scl_s;
  wire          adv   = tick && !stall;
  wire          lost  = (st == S_WRITE) && ph >= 4'd8 && shr[7] && !sda_s;
  wire          go    = (st == S_IDLE) && cmd_start && bus_idle;

  assign busy = (st != S_IDLE);

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: sda_oe = (ph >= 4'd4);
      S_HOLD:  begin scl_oe = 1'b1; sda_oe = hold_sda; end
      S_WRITE: begin scl_oe = (ph < 4'd6); sda_oe = !shr[7]; end
      S_STOP:  begin scl_oe = (ph < 4'd6); sda_oe = (ph < 4'd10); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy   <= 2'b11;
      sda_sy   <= 2'b11;
      sda_p    <= 1'b1;
      bus_idle <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      sda_p  <= sda_s;
      if (scl_s && sda_p && !sda_s)      bus_idle <= 1'b0;
      else if (scl_s && !sda_p && sda_s) bus_idle <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (st == S_IDLE || st == S_HOLD || st == S_BACK) begin
      pcnt <= '0;
    end else if (tick) begin
      pcnt <= stall ? pcnt : '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tpr_q    <= '0;
      ph       <= '0;
      nbit     <= '0;
      shr      <= '0;
      hold_sda <= 1'b0;
      done     <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          st       <= S_START;
          ph       <= '0;
          tpr_q    <= tpr;
          arb_lost <= 1'b0;
        end
        S_START: if (adv) begin
          if (ph == 4'd9) begin
            st       <= S_HOLD;
            hold_sda <= 1'b1;
            done     <= 1'b1;
          end else ph <= ph + 1'b1;
        end
        S_HOLD: if (cmd_write) begin
          st   <= S_WRITE;
          shr  <= wr_byte;
          nbit <= '0;
          ph   <= '0;
        end else if (cmd_stop) begin
          st <= S_STOP;
          ph <= '0;
        end
        S_WRITE: if (lost) begin
          st       <= S_BACK;
          arb_lost <= 1'b1;
        end else if (adv) begin
          if (ph == 4'd9) begin
            ph <= '0;
            if (nbit == 3'd7) begin
              st       <= S_HOLD;
              hold_sda <= !shr[7];
              done     <= 1'b1;
            end else begin
              nbit <= nbit + 1'b1;
              shr  <= {shr[6:0], 1'b0};
            end
          end else ph <= ph + 1'b1;
        end
        S_STOP: if (adv) begin
          if (ph == 4'd13) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else ph <= ph + 1'b1;
        end
        S_BACK: if (bus_idle) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_mm_bit_engine_chk.sv
module i2c_mm_bit_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_start,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic bus_idle,
  input logic done,
  input logic arb_lost
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_start_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cmd_start) && $past(bus_idle)));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_end_reason_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || arb_lost));

  assert_release_on_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (!scl_oe && !sda_oe));

  assert_backoff_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && busy) |-> (!scl_oe && !sda_oe));

  assert_sticky_lost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arb_lost) |-> $past(cmd_start));
endmodule

bind i2c_mm_bit_engine i2c_mm_bit_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .busy(busy), .bus_idle(bus_idle), .done(done), .arb_lost(arb_lost)
);

// File: tb/sim_i2c_mm_bit_engine.sv
`timescale 1ns/1ps
module sim_i2c_mm_bit_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tpr = 8'd2;
  logic       cmd_start = 1'b0, cmd_write = 1'b0, cmd_stop = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       x_scl = 1'b0, x_sda = 1'b0;
  logic       scl_oe, sda_oe, busy, bus_idle, done, arb_lost;

  wire scl_line = !(scl_oe || x_scl);
  wire sda_line = !(sda_oe || x_sda);

  always #5 clk = ~clk;

  i2c_mm_bit_engine #(.TPR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tpr(tpr), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .cmd_stop(cmd_stop), .wr_byte(wr_byte), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .bus_idle(bus_idle), .done(done),
    .arb_lost(arb_lost)
  );

  int errs = 0, nchk = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: mode 0 idle,1 start,2 hold,3 write,4 stop,5 back-off
  int  mm, t, L, nb;
  logic [7:0] by;
  bit  hs, md, ml, mi, s1c, s2c, s1d, s2d, pd, mlost, stl;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mm = 0; t = 0; L = 2; nb = 0; by = 0; hs = 0; md = 0; ml = 0; mi = 1;
      s1c = 1; s2c = 1; s1d = 1; s2d = 1; pd = 1;
    end else begin
      mlost = (mm == 3) && (t >= 8*L) && by[7] && !s2d;
      stl   = (mm == 3 || mm == 4) && (t == 8*L-1) && !s2c;
      md = 0;
      case (mm)
        0: if (cmd_start && mi) begin mm = 1; t = 0; L = 2*(int'(tpr)+1); ml = 0; end
        1: if (t == 10*L-1) begin mm = 2; hs = 1; md = 1; end else t++;
        2: if (cmd_write) begin mm = 3; t = 0; nb = 0; by = wr_byte; end
           else if (cmd_stop) begin mm = 4; t = 0; end
        3: if (mlost) begin mm = 5; ml = 1; end
           else if (!stl) begin
             if (t == 10*L-1) begin
               if (nb == 7) begin mm = 2; hs = !by[7]; md = 1; end
               else begin nb++; by = by << 1; t = 0; end
             end else t++;
           end
        4: if (!stl) begin
             if (t == 14*L-1) begin mm = 0; md = 1; end else t++;
           end
        5: if (mi) mm = 0;
        default: mm = 0;
      endcase
      if (s2c && pd && !s2d)      mi = 0;
      else if (s2c && !pd && s2d) mi = 1;
      pd = s2d; s2c = s1c; s1c = scl_line; s2d = s1d; s1d = sda_line;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit es, ed;
      es = (mm == 2) || ((mm == 3 || mm == 4) && (t/L) < 6);
      ed = (mm == 1 && (t/L) >= 4) || (mm == 2 && hs) || (mm == 3 && !by[7]) ||
           (mm == 4 && (t/L) < 10);
      chk(scl_oe == es, "R2 scl_oe", scl_oe, es);
      chk(sda_oe == ed, "R4 sda_oe", sda_oe, ed);
      chk(busy == (mm != 0), "R3 busy", busy, mm != 0);
      chk(done == md, "R5 done", done, md);
      chk(arb_lost == ml, "R7 arb_lost", arb_lost, ml);
      chk(bus_idle == mi, "R6 bus_idle", bus_idle, mi);
    end
  end

  always @(posedge clk) if (cyc > 150000) begin
    errs++; nchk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) cmd_start = 1; else if (which == 1) cmd_write = 1; else cmd_stop = 1;
    @(negedge clk);
    cmd_start = 0; cmd_write = 0; cmd_stop = 0;
  endtask

  task automatic wait_done;
    forever begin @(negedge clk); if (done) break; end
  endtask

  task automatic next_release(output int c);
    logic prev;
    prev = scl_oe;
    forever begin
      @(negedge clk);
      if (prev && !scl_oe) break;
      prev = scl_oe;
    end
    c = cyc;
  endtask

  initial begin
    int a, b;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done && !arb_lost && bus_idle, "R1 reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && bus_idle, "R1 after reset", scl_oe, 0);

    // idle commands ignored
    wr_byte = 8'hC3;
    pulse(1); pulse(2);
    repeat (3) @(negedge clk);
    chk(!busy && !scl_oe && !sda_oe, "R11 write/stop in idle", busy, 0);

    // full transfer, tpr=2
    tpr = 8'd2;
    pulse(0);
    wait_done();
    chk(scl_oe && sda_oe, "R3 start end state", {scl_oe, sda_oe}, 3);
    wr_byte = 8'hA5;
    pulse(1);
    next_release(a); next_release(b);
    chk(b - a == 60, "R2 bit period tpr=2", b - a, 60);
    wait_done();
    chk(scl_oe && !sda_oe, "R4 hold after last bit 1", sda_oe, 0);
    wr_byte = 8'h3C;
    pulse(1);
    next_release(a);
    x_scl = 1;
    repeat (30) @(negedge clk);
    x_scl = 0;
    next_release(b);
    chk(b - a > 60, "R9 stretched period", b - a, 61);
    wait_done();
    chk(scl_oe && sda_oe, "R4 hold after last bit 0", sda_oe, 1);
    pulse(2);
    wait_done();
    chk(!busy && bus_idle, "R5 stop leaves bus idle", busy, 0);

    // tpr change mid-transfer
    tpr = 8'd0;
    pulse(0);
    tpr = 8'd5;
    wait_done();
    wr_byte = 8'h5A;
    pulse(1);
    next_release(a); next_release(b);
    chk(b - a == 20, "R10 period kept at tpr=0", b - a, 20);
    wait_done();
    pulse(2);
    wait_done();

    // external START/STOP
    x_sda = 1;
    repeat (5) @(negedge clk);
    chk(!bus_idle, "R6 external start", bus_idle, 0);
    pulse(0);
    repeat (3) @(negedge clk);
    chk(!busy && !scl_oe, "R11 start on busy bus", busy, 0);
    x_sda = 0;
    repeat (5) @(negedge clk);
    chk(bus_idle, "R6 external stop", bus_idle, 1);

    // arbitration loss in bit 3 of 0x1F, tpr=1 (L=4)
    tpr = 8'd1;
    pulse(0);
    wait_done();
    x_sda = 1;
    wr_byte = 8'h1F;
    pulse(1);
    repeat (118) @(negedge clk);
    chk(!arb_lost, "R7 no loss on 0 bits", arb_lost, 0);
    repeat (42) @(negedge clk);
    chk(arb_lost, "R7 loss on first 1 bit", arb_lost, 1);
    chk(busy && !scl_oe && !sda_oe, "R7 back-off releases lines", {busy, scl_oe, sda_oe}, 4);
    x_sda = 0;
    repeat (6) @(negedge clk);
    chk(!busy && bus_idle, "R7 idle after bus stop", busy, 0);
    chk(arb_lost, "R8 flag sticky", arb_lost, 1);
    pulse(0);
    chk(!arb_lost && busy, "R8 cleared by start", arb_lost, 0);
    wait_done();
    pulse(2);
    wait_done();
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule